// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a 16-bit virtual address onto a wider physical address using a table of sixteen segment descriptors. The top four address bits choose a descriptor. The remaining twelve bits form an offset inside that segment. Each descriptor holds a physical base, a bound and a valid flag. The offset is tested against the bound while, in the same cycle, it is added to the base. A legal access returns the sum. An illegal access raises a trap, and the physical address is driven to zero.

The descriptors are loaded through a write port. The port accepts a write only while the privileged-mode input is high, so only the kernel can rewrite the table when it switches processes. To move a process in physical memory, the kernel rewrites only the base of each of its segments. Lookups are qualified by a request-valid input. The result is registered, so it appears one clock after the request. The unit keeps the virtual address of the most recent trapping access until the next trap.

Top module: `seg_xlate_unit`

## Requirements
- R1: After synchronous reset, `rsp_valid`, `rsp_paddr`, both fault flags, `trap` and `fault_vaddr` are all zero, and every descriptor is invalid. A lookup made straight after reset therefore reports a segment fault.
- R2: Virtual address bits [15:12] select descriptor 0 to 15, and bits [11:0] are the unsigned offset.
- R3: If the selected descriptor is valid and the offset is less than its 13-bit bound, `rsp_paddr` equals base plus offset, truncated to 20 bits. In this case `trap` and both fault flags stay low.
- R4: If the selected descriptor is valid and the offset is greater than or equal to its bound, `rsp_bound_fault` and `trap` are 1, `rsp_seg_fault` is 0 and `rsp_paddr` is 0. A bound of 0 rejects every offset, and a bound of 4096 accepts every offset.
- R5: If the selected descriptor is invalid, `rsp_seg_fault` and `trap` are 1, `rsp_bound_fault` is 0 and `rsp_paddr` is 0, whatever the bound holds.
- R6: A request sampled with `req_valid` high at one rising edge produces `rsp_valid` = 1 at that same edge, so the result is visible one cycle later. A cycle without a request leaves `rsp_valid`, `rsp_paddr`, the fault flags and `trap` at 0.
- R7: When `trap` rises, `fault_vaddr` holds the faulting virtual address. It keeps that value through every later response that does not trap.
- R8: A table write with `tbl_we` high is accepted only while `priv_mode` is high. It replaces the valid flag, base and bound of descriptor `tbl_idx`. A write attempted with `priv_mode` low leaves the table unchanged.
- R9: A write takes effect for requests sampled at the following edges. A lookup sampled at the same edge as a write to the same descriptor uses the old contents.
- R10: Rewriting only the base of a descriptor moves its translations by the change in base. The set of offsets that fault stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | High when the kernel is issuing table writes |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 4 | Descriptor index to write |
| tbl_valid | input | 1 | Valid flag to store |
| tbl_base | input | 20 | Physical base to store |
| tbl_bound | input | 13 | Segment length in bytes, 0 to 4096 |
| req_valid | input | 1 | Qualifies the lookup of `req_vaddr` |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | A registered result is present |
| rsp_paddr | output | 20 | Translated physical address, or 0 on a trap |
| rsp_seg_fault | output | 1 | The selected descriptor was invalid |
| rsp_bound_fault | output | 1 | The offset was outside the bound |
| trap | output | 1 | Either fault occurred |
| fault_vaddr | output | 16 | Virtual address of the last trapping access |

## Verification
The checker watches the invariants on every cycle:
- a response follows exactly one cycle after a request;
- the two fault kinds never appear together;
- a trap always zeroes the physical address and loads the faulting address;
- the captured address holds steady whenever no trap occurs.

The values of the translations themselves can only be shown by the bench's scenarios:
- the base-plus-offset sums, including wrap-around at 20 bits;
- the exact edge where the offset meets the bound;
- the rejection of unprivileged writes;
- the ordering of a write and a lookup on the same edge;
- the effect of relocating a process.

The bench covers these with sweeps over every descriptor and around every bound.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    parameter int VA_W   = 16;
    parameter int SEL_W  = 4;
    parameter int OFS_W  = VA_W - SEL_W;
    parameter int NSEG   = 1 << SEL_W;
    parameter int PA_W   = 20;
    parameter int BND_W  = OFS_W + 1;

    typedef logic [VA_W-1:0]  vaddr_t;
    typedef logic [SEL_W-1:0] seg_sel_t;
    typedef logic [OFS_W-1:0] seg_ofs_t;
    typedef logic [PA_W-1:0]  paddr_t;
    typedef logic [BND_W-1:0] bound_t;

    typedef struct packed {
        logic   valid;
        paddr_t base;
        bound_t bound;
    } seg_desc_t;

    typedef enum logic [1:0] {
        XS_OK    = 2'd0,
        XS_SEG   = 2'd1,
        XS_BOUND = 2'd2
    } xlate_stat_e;

    typedef struct packed {
        xlate_stat_e stat;
        paddr_t      paddr;
    } xlate_res_t;

    function automatic seg_sel_t va_sel(input vaddr_t va);
        return va[VA_W-1 -: SEL_W];
    endfunction

    function automatic seg_ofs_t va_ofs(input vaddr_t va);
        return va[OFS_W-1:0];
    endfunction

    function automatic seg_desc_t empty_desc();
        seg_desc_t d;
        d.valid = 1'b0;
        d.base  = '0;
        d.bound = '0;
        return d;
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_req,
    input  logic      wr_priv,
    input  seg_sel_t  wr_idx,
    input  seg_desc_t wr_desc,
    output seg_desc_t desc_q [NSEG]
);

    logic wr_ok;
    assign wr_ok = wr_req & wr_priv;

    for (genvar g = 0; g < NSEG; g++) begin : g_desc
        logic hit;
        assign hit = wr_ok && (wr_idx == seg_sel_t'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                desc_q[g] <= empty_desc();
            end else if (hit) begin
                desc_q[g] <= wr_desc;
            end
        end
    end

endmodule

// File: rtl/seg_lookup.sv
module seg_lookup
    import seg_xlate_pkg::*;
(
    input  seg_desc_t  desc_i [NSEG],
    input  vaddr_t     vaddr,
    output xlate_res_t res
);

    seg_sel_t  sel;
    seg_ofs_t  ofs;
    seg_desc_t cur;
    logic      in_range;
    paddr_t    sum;

    assign sel = va_sel(vaddr);
    assign ofs = va_ofs(vaddr);

    always_comb begin
        cur = empty_desc();
        for (int i = 0; i < NSEG; i++) begin
            if (sel == seg_sel_t'(i)) cur = desc_i[i];
        end
    end

    // compare and add run side by side; result picked afterwards
    assign in_range = bound_t'(ofs) < cur.bound;
    assign sum      = cur.base + paddr_t'(ofs);

    always_comb begin
        if (!cur.valid) begin
            res.stat  = XS_SEG;
            res.paddr = '0;
        end else if (!in_range) begin
            res.stat  = XS_BOUND;
            res.paddr = '0;
        end else begin
            res.stat  = XS_OK;
            res.paddr = sum;
        end
    end

endmodule

// File: rtl/seg_result_reg.sv
module seg_result_reg
    import seg_xlate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  vaddr_t     req_vaddr,
    input  xlate_res_t res_d,
    output logic       rsp_valid,
    output paddr_t     rsp_paddr,
    output logic       rsp_seg_fault,
    output logic       rsp_bound_fault,
    output logic       trap,
    output vaddr_t     fault_vaddr
);

    logic is_seg, is_bnd;
    assign is_seg = req_valid && (res_d.stat == XS_SEG);
    assign is_bnd = req_valid && (res_d.stat == XS_BOUND);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid       <= 1'b0;
            rsp_paddr       <= '0;
            rsp_seg_fault   <= 1'b0;
            rsp_bound_fault <= 1'b0;
            trap            <= 1'b0;
            fault_vaddr     <= '0;
        end else begin
            rsp_valid       <= req_valid;
            rsp_paddr       <= (req_valid && res_d.stat == XS_OK) ? res_d.paddr : '0;
            rsp_seg_fault   <= is_seg;
            rsp_bound_fault <= is_bnd;
            trap            <= is_seg | is_bnd;
            if (is_seg | is_bnd) fault_vaddr <= req_vaddr;
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               priv_mode,
    input  logic               tbl_we,
    input  logic [SEL_W-1:0]   tbl_idx,
    input  logic               tbl_valid,
    input  logic [PA_W-1:0]    tbl_base,
    input  logic [BND_W-1:0]   tbl_bound,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_seg_fault,
    output logic               rsp_bound_fault,
    output logic               trap,
    output logic [VA_W-1:0]    fault_vaddr
);

    seg_desc_t  table_q [NSEG];
    seg_desc_t  wr_desc;
    xlate_res_t lk_res;

    assign wr_desc.valid = tbl_valid;
    assign wr_desc.base  = tbl_base;
    assign wr_desc.bound = tbl_bound;

    seg_desc_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (tbl_we),
        .wr_priv (priv_mode),
        .wr_idx  (tbl_idx),
        .wr_desc (wr_desc),
        .desc_q  (table_q)
    );

    seg_lookup u_lookup (
        .desc_i (table_q),
        .vaddr  (req_vaddr),
        .res    (lk_res)
    );

    seg_result_reg u_result (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_vaddr       (req_vaddr),
        .res_d           (lk_res),
        .rsp_valid       (rsp_valid),
        .rsp_paddr       (rsp_paddr),
        .rsp_seg_fault   (rsp_seg_fault),
        .rsp_bound_fault (rsp_bound_fault),
        .trap            (trap),
        .fault_vaddr     (fault_vaddr)
    );

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker
    import seg_xlate_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_seg_fault,
    input logic             rsp_bound_fault,
    input logic             trap,
    input logic [VA_W-1:0]  fault_vaddr
);

    assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !trap && rsp_paddr == '0));

    assert_fault_kinds_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_seg_fault, rsp_bound_fault}));

    assert_trap_zero_paddr_R4: assert property (@(posedge clk) disable iff (rst)
        trap |-> (rsp_paddr == '0 && rsp_valid));

    assert_trap_needs_fault_R4: assert property (@(posedge clk) disable iff (rst)
        trap |-> (rsp_seg_fault || rsp_bound_fault));

    assert_capture_on_trap_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid ##1 trap) |-> (fault_vaddr == $past(req_vaddr)));

    assert_hold_without_trap_R7: assert property (@(posedge clk) disable iff (rst)
        !trap |=> (trap || $stable(fault_vaddr)));

endmodule

bind seg_xlate_unit seg_xlate_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_vaddr       (req_vaddr),
    .rsp_valid       (rsp_valid),
    .rsp_paddr       (rsp_paddr),
    .rsp_seg_fault   (rsp_seg_fault),
    .rsp_bound_fault (rsp_bound_fault),
    .trap            (trap),
    .fault_vaddr     (fault_vaddr)
);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        priv_mode, tbl_we, tbl_valid, req_valid;
    logic [3:0]  tbl_idx;
    logic [19:0] tbl_base;
    logic [12:0] tbl_bound;
    logic [15:0] req_vaddr;
    logic        rsp_valid, rsp_seg_fault, rsp_bound_fault, trap;
    logic [19:0] rsp_paddr;
    logic [15:0] fault_vaddr;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    logic        m_valid [16];
    logic [19:0] m_base  [16];
    logic [12:0] m_bound [16];
    logic [15:0] m_fva;

    always #2 clk = ~clk;

    seg_xlate_unit dut (
        .clk(clk), .rst(rst), .priv_mode(priv_mode), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_base(tbl_base),
        .tbl_bound(tbl_bound), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_seg_fault(rsp_seg_fault),
        .rsp_bound_fault(rsp_bound_fault), .trap(trap), .fault_vaddr(fault_vaddr)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL R6 watchdog: actual=%0d cycles expected=<100000", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic v, input logic [19:0] b,
                      input logic [12:0] bd, input logic priv);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx[3:0]; tbl_valid = v; tbl_base = b;
        tbl_bound = bd; priv_mode = priv;
        @(negedge clk);
        tbl_we = 1'b0; priv_mode = 1'b0;
        if (priv) begin
            m_valid[idx] = v; m_base[idx] = b; m_bound[idx] = bd;
        end
    endtask

    // expected response computed from the model table, then compared
    task automatic lookup(input logic [15:0] va, input string req);
        int s;
        logic [12:0] o;
        logic [19:0] ep;
        logic es, eb;
        s = int'(va[15:12]);
        o = {1'b0, va[11:0]};
        es = !m_valid[s];
        eb = m_valid[s] && (o >= m_bound[s]);
        ep = (es || eb) ? 20'h0 : m_base[s] + {8'h0, va[11:0]};
        if (es || eb) m_fva = va;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, {rsp_valid, rsp_seg_fault, rsp_bound_fault, trap, rsp_paddr, fault_vaddr},
                 {1'b1, es, eb, es | eb, ep, m_fva});
    endtask

    initial begin
        rst = 1'b1; priv_mode = 0; tbl_we = 0; tbl_idx = 0; tbl_valid = 0;
        tbl_base = 0; tbl_bound = 0; req_valid = 0; req_vaddr = 0;
        m_fva = 16'h0;
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 0; m_base[i] = 0; m_bound[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {rsp_valid, rsp_seg_fault, rsp_bound_fault, trap, rsp_paddr, fault_vaddr}, 64'h0);
        lookup(16'h5123, "R1 table invalid after reset");
        // R6 idle cycle
        @(negedge clk);
        chk("R6 idle response", {rsp_valid, trap, rsp_paddr}, 64'h0);

        // R8 load all descriptors
        for (int s = 0; s < 16; s++) begin
            logic [12:0] bd;
            bd = (s == 0) ? 13'd0 : (s == 1) ? 13'h1000 : 13'(s * 250 + 1);
            wr(s, (s % 5) != 3, 20'(s * 20'h1100 + 20'h0ff00), bd, 1'b1);
        end

        // R2 R3 R4 R5 sweep over every descriptor and around every bound
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 16; k++) begin
                lookup({4'(s), 12'(k * 12'h111)}, "R3 sweep");
            end
            lookup({4'(s), 12'h000}, "R4 offset zero");
            lookup({4'(s), 12'hfff}, "R4 offset max");
            if (m_bound[s] != 0 && m_bound[s] <= 13'hfff) begin
                lookup({4'(s), 12'(m_bound[s] - 1)}, "R3 last legal offset");
                lookup({4'(s), m_bound[s][11:0]}, "R4 first illegal offset");
            end
            if (!m_valid[s]) lookup({4'(s), 12'h001}, "R5 invalid segment");
        end

        // R3 wrap at 20 bits
        wr(7, 1'b1, 20'hffff0, 13'h1000, 1'b1);
        lookup(16'h7020, "R3 wrap sum");

        // R8 unprivileged write ignored
        wr(2, 1'b0, 20'h12345, 13'd0, 1'b0);
        lookup(16'h2010, "R8 unprivileged write ignored");
        wr(2, 1'b0, 20'h12345, 13'd0, 1'b1);
        lookup(16'h2010, "R8 privileged write invalidates");

        // R7 hold across successful accesses
        lookup(16'h0005, "R7 trap capture");
        lookup(16'h1abc, "R7 hold on success");
        lookup(16'h4002, "R7 hold on success");

        // R9 same-edge write and lookup
        @(negedge clk);
        tbl_we = 1'b1; priv_mode = 1'b1; tbl_idx = 4'd4; tbl_valid = 1'b1;
        tbl_base = 20'h80000; tbl_bound = 13'd16;
        req_valid = 1'b1; req_vaddr = 16'h4100;
        @(negedge clk);
        tbl_we = 1'b0; priv_mode = 1'b0; req_valid = 1'b0;
        chk("R9 same edge uses old entry", {rsp_valid, trap, rsp_paddr},
            {1'b1, 1'b0, m_base[4] + 20'h100});
        m_valid[4] = 1'b1; m_base[4] = 20'h80000; m_bound[4] = 13'd16;
        lookup(16'h4100, "R9 next request sees new entry");
        lookup(16'h400f, "R9 next request sees new entry");

        // R10 relocation by base only
        wr(9, 1'b1, 20'h30000, 13'd100, 1'b1);
        lookup(16'h9063, "R10 before move");
        lookup(16'h9064, "R10 before move bound");
        wr(9, 1'b1, 20'h51230, 13'd100, 1'b1);
        lookup(16'h9063, "R10 after move");
        lookup(16'h9064, "R10 after move bound");

        summary();
    end

endmodule